// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block tracks shaft position from an incremental encoder. It takes the two phase signals and the once-per-revolution marker, cleans each one with a majority-free stability filter, and decodes every edge of both phases into a signed step of a wrapping 32-bit position count. The filter's sampling rate can be set to the core clock or to half of it. This lets slow or noisy encoders be filtered over a longer window without adding flops.

The marker input can zero the count. In direct mode this happens on the marker's rising edge. In qualified mode it waits until both phases are low while the marker is high. A compare value, written through a strobe, raises a single-cycle match pulse whenever an update lands on it. A snapshot strobe freezes the current count into a separate output so that a reader sees a coherent value. An update in which both phases change together is discarded and latches a fault bit. Mode bits come in on plain configuration pins.

Top module: `qdc_counter`

## Requirements
- R1: After reset the count, the snapshot, the match pulse and the fault bit are all zero, and the compare value is zero, so the first update that returns the count to 0 produces a match pulse.
- R2: A filtered input takes a new level only after two consecutive filter samples agree on it, so a raw pulse lasting one clock is ignored.
- R3: With `cfg_fdiv2`=0 the filter samples every clock and accepts a pulse of two clocks; with `cfg_fdiv2`=1 it samples every second clock, and a pulse of two clocks is ignored while one of four clocks is accepted.
- R4: With the phase state written {A,B}, the order 00→10→11→01→00 (A leading B) adds one to the count on every edge.
- R5: The reverse order 00→01→11→10→00 (B leading A) subtracts one on every edge.
- R6: The count wraps modulo 2^32: one step down from 0 gives 0xFFFFFFFF, and one step up from there gives 0.
- R7: While `cnt_en` is low, phase edges do not change the count; the phase history still follows the inputs, so counting resumes correctly once `cnt_en` returns high.
- R8: An update in which both filtered phases change together leaves the count unchanged, sets `err_flag`, and `err_flag` stays set until reset.
- R9: With `cfg_idx_clr`=1 and `cfg_idx_sync`=0, the rising edge of the filtered marker clears the count to 0 once per marker pulse. With `cfg_idx_clr`=0 the marker has no effect.
- R10: With `cfg_idx_clr`=1 and `cfg_idx_sync`=1, a marker pulse clears the count only in a cycle where the marker is high and the filtered phases are both 0. That clear overrides a step that arrives in the same cycle.
- R11: `cmp_wr` loads `cmp_din` as the compare value. `cmp_flag` is high for exactly one clock, in the first cycle in which `count_q` shows an updated value equal to it.
- R12: `snap_ld` copies `count_q` into `snap_q` at the next clock edge, and `snap_q` holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_fdiv2 | input | 1 | Filter samples every second clock when high |
| cfg_idx_clr | input | 1 | Marker clears the count when high |
| cfg_idx_sync | input | 1 | Marker clear qualified by phase state 00 when high |
| cnt_en | input | 1 | Counting enable |
| enc_a | input | 1 | Raw phase A |
| enc_b | input | 1 | Raw phase B |
| enc_idx | input | 1 | Raw index marker |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_din | input | 32 | Compare value to load |
| snap_ld | input | 1 | Snapshot strobe |
| count_q | output | 32 | Live position count |
| snap_q | output | 32 | Frozen copy of the count |
| cmp_flag | output | 1 | One-clock match pulse |
| err_flag | output | 1 | Sticky fault bit for a double phase change |

## Verification
The qualified marker clear is the hardest case to reach. It needs the marker held high while the phases sit away from 00, and then a phase edge that both moves the state to 00 and would step the count in the same cycle. The bench walks the phases up to state 10 and raises the marker there. It checks that nothing is cleared yet, then steps down into 00 and expects 0 rather than the decremented value. The divide mode is reached by pulses whose length is fixed relative to the sample phase: two-clock marker pulses must clear only at full rate.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

   typedef enum logic [1:0] {
      MV_NONE = 2'd0,
      MV_UP   = 2'd1,
      MV_DN   = 2'd2,
      MV_BAD  = 2'd3
   } qdc_move_e;

   // Classify one transition of the filtered phase pair.
   function automatic qdc_move_e qdc_classify(input logic pa, input logic pb,
                                               input logic a,  input logic b);
      qdc_move_e mv;
      if ((pa == a) && (pb == b))      mv = MV_NONE;
      else if ((pa != a) && (pb != b)) mv = MV_BAD;
      else if (a ^ pb)                 mv = MV_UP;
      else                             mv = MV_DN;
      return mv;
   endfunction

endpackage

// File: rtl/qdc_filter.sv
module qdc_filter #(
   parameter int CH    = 3,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CH-1:0] raw,
   output logic [CH-1:0] filt
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("qdc_filter: DEPTH must be at least 2");
   end
   if (CH < 1) begin : g_bad_ch
      $error("qdc_filter: CH must be at least 1");
   end

   for (genvar g = 0; g < CH; g++) begin : g_ch
      logic [DEPTH-2:0] hist_r;
      logic [DEPTH-1:0] win;
      logic             lvl_r;

      assign win = {hist_r, raw[g]};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_r <= '0;
            lvl_r  <= 1'b0;
         end else if (tick) begin
            hist_r <= win[DEPTH-2:0];
            if (&win)       lvl_r <= 1'b1;
            else if (~|win) lvl_r <= 1'b0;
         end
      end

      assign filt[g] = lvl_r;

      AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !tick |=> $stable(filt[g]))
         else $error("filtered level moved without a sample tick"); // R3
   end

endmodule

// File: rtl/qdc_decode.sv
module qdc_decode
   import qdc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic a,
   input  logic b,
   input  logic idx,
   input  logic cfg_idx_clr,
   input  logic cfg_idx_sync,
   output logic step_up,
   output logic step_dn,
   output logic clr,
   output logic err_flag
);

   logic      pa_r, pb_r, pidx_r, pend_r, err_r;
   qdc_move_e mv;
   logic      idx_rise, armed, fire;

   assign mv       = qdc_classify(pa_r, pb_r, a, b);
   assign idx_rise = idx & ~pidx_r;
   assign armed    = idx & (idx_rise | pend_r);

   always_comb begin
      if (!cfg_idx_clr)      fire = 1'b0;
      else if (cfg_idx_sync) fire = armed & ~a & ~b;
      else                   fire = idx_rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_r   <= 1'b0;
         pb_r   <= 1'b0;
         pidx_r <= 1'b0;
         pend_r <= 1'b0;
         err_r  <= 1'b0;
      end else begin
         pa_r   <= a;
         pb_r   <= b;
         pidx_r <= idx;
         pend_r <= armed & ~fire;
         if (mv == MV_BAD) err_r <= 1'b1;
      end
   end

   assign step_up  = (mv == MV_UP);
   assign step_dn  = (mv == MV_DN);
   assign clr      = fire;
   assign err_flag = err_r;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_r |=> err_r)
      else $error("fault bit dropped without reset"); // R8

endmodule

// File: rtl/qdc_core.sv
module qdc_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             clr,
   input  logic             cnt_en,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_din,
   input  logic             snap_ld,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] snap_q,
   output logic             cmp_flag
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_r, cmp_r, snap_r, nxt;
   logic             upd, flag_r;

   assign upd = clr | (cnt_en & (step_up | step_dn));

   always_comb begin
      if (clr)          nxt = '0;
      else if (step_up) nxt = cnt_r + ONE;
      else              nxt = cnt_r - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r  <= '0;
         cmp_r  <= '0;
         snap_r <= '0;
         flag_r <= 1'b0;
      end else begin
         if (upd)     cnt_r  <= nxt;
         if (cmp_wr)  cmp_r  <= cmp_din;
         if (snap_ld) snap_r <= cnt_r;
         flag_r <= upd & (nxt == cmp_r);
      end
   end

   assign count_q  = cnt_r;
   assign snap_q   = snap_r;
   assign cmp_flag = flag_r;

   AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_r && !$past(cmp_wr)) |-> (cnt_r == cmp_r))
      else $error("match pulse without equal count"); // R11
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_r != $past(cnt_r)) |->
         ((cnt_r == $past(cnt_r) + ONE) || (cnt_r == $past(cnt_r) - ONE) || (cnt_r == '0)))
      else $error("count moved by more than one step"); // R6
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_ld |=> $stable(snap_r))
      else $error("snapshot changed without strobe"); // R12

endmodule

// File: rtl/qdc_counter.sv
module qdc_counter #(
   parameter int CNT_W      = 32,
   parameter int FILT_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_fdiv2,
   input  logic             cfg_idx_clr,
   input  logic             cfg_idx_sync,
   input  logic             cnt_en,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_idx,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_din,
   input  logic             snap_ld,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] snap_q,
   output logic             cmp_flag,
   output logic             err_flag
);

   localparam int N_IN = 3;

   if (CNT_W < 2) begin : g_bad_width
      $error("qdc_counter: CNT_W must be at least 2");
   end

   logic            ph_r, tick;
   logic [N_IN-1:0] raw, filt;
   logic            up, dn, clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_r <= 1'b0;
      else        ph_r <= ~ph_r;
   end

   assign tick = ~cfg_fdiv2 | ph_r;
   assign raw  = {enc_idx, enc_b, enc_a};

   qdc_filter #(.CH(N_IN), .DEPTH(FILT_DEPTH)) filt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .raw  (raw),
      .filt (filt)
   );

   qdc_decode dec_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .a           (filt[0]),
      .b           (filt[1]),
      .idx         (filt[2]),
      .cfg_idx_clr (cfg_idx_clr),
      .cfg_idx_sync(cfg_idx_sync),
      .step_up     (up),
      .step_dn     (dn),
      .clr         (clr),
      .err_flag    (err_flag)
   );

   qdc_core #(.CNT_W(CNT_W)) core_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_up (up),
      .step_dn (dn),
      .clr     (clr),
      .cnt_en  (cnt_en),
      .cmp_wr  (cmp_wr),
      .cmp_din (cmp_din),
      .snap_ld (snap_ld),
      .count_q (count_q),
      .snap_q  (snap_q),
      .cmp_flag(cmp_flag)
   );

endmodule

// File: tb/qdc_counter_tb.sv
module qdc_counter_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_fdiv2 = 1'b0, cfg_idx_clr = 1'b0, cfg_idx_sync = 1'b0;
   logic        cnt_en = 1'b1;
   logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
   logic        cmp_wr = 1'b0, snap_ld = 1'b0;
   logic [31:0] cmp_din = '0;
   logic [31:0] count_q, snap_q;
   logic        cmp_flag, err_flag;

   int          nchk = 0, nerr = 0, pls = 0, exp_pls = 0, wc = 6;
   logic [31:0] exp_cnt = '0, exp_cmp = '0;
   logic [1:0]  ab_st = 2'b00;

   always #(CLK_PERIOD/2) clk = ~clk;

   qdc_counter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_fdiv2(cfg_fdiv2), .cfg_idx_clr(cfg_idx_clr),
      .cfg_idx_sync(cfg_idx_sync), .cnt_en(cnt_en), .enc_a(enc_a), .enc_b(enc_b),
      .enc_idx(enc_idx), .cmp_wr(cmp_wr), .cmp_din(cmp_din), .snap_ld(snap_ld),
      .count_q(count_q), .snap_q(snap_q), .cmp_flag(cmp_flag), .err_flag(err_flag)
   );

   always @(negedge clk) if (rst_n && cmp_flag) pls++;

   // Phase order for {A,B}: up 00->10->11->01->00, down reversed.
   function automatic logic [1:0] gray_next(input logic [1:0] s, input bit up);
      logic [1:0] n;
      case (s)
         2'b00:   n = up ? 2'b10 : 2'b01;
         2'b10:   n = up ? 2'b11 : 2'b00;
         2'b11:   n = up ? 2'b01 : 2'b10;
         default: n = up ? 2'b00 : 2'b11;
      endcase
      return n;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exv);
      nchk++;
      if (act !== exv) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exv);
      end
   endtask

   task automatic step(input bit up);
      ab_st = gray_next(ab_st, up);
      enc_a = ab_st[1];
      enc_b = ab_st[0];
      if (cnt_en) begin
         exp_cnt = up ? exp_cnt + 32'd1 : exp_cnt - 32'd1;
         if (exp_cnt == exp_cmp) exp_pls++;
      end
      repeat (wc) @(negedge clk);
   endtask

   task automatic idx_pulse(input int len);
      enc_idx = 1'b1;
      repeat (len) @(negedge clk);
      enc_idx = 1'b0;
      repeat (wc) @(negedge clk);
   endtask

   task automatic write_cmp(input logic [31:0] v);
      cmp_din = v; cmp_wr = 1'b1;
      @(negedge clk);
      cmp_wr = 1'b0;
      exp_cmp = v;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog all requirements actual=hang expected=finish");
      summary();
   end

   initial begin
      int p0;
      logic [31:0] hold;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 count", count_q, 32'd0);
      chk("R1 snap", snap_q, 32'd0);
      chk("R1 flags", {30'd0, cmp_flag, err_flag}, 32'd0);

      p0 = pls;
      step(0);
      chk("R6 wrap down", count_q, 32'hFFFF_FFFF);
      step(1);
      chk("R6 wrap up", count_q, 32'd0);
      chk("R1 compare zero pulse", pls - p0, 1);

      repeat (4) step(1);
      chk("R4 up x4", count_q, 32'd4);
      repeat (2) step(0);
      chk("R5 down", count_q, 32'd2);

      // R2: one-clock glitch on A
      enc_a = ~enc_a;
      @(negedge clk);
      enc_a = ab_st[1];
      repeat (wc) @(negedge clk);
      chk("R2 glitch ignored", count_q, 32'd2);

      cnt_en = 1'b0;
      repeat (3) step(1);
      chk("R7 disabled hold", count_q, 32'd2);
      cnt_en = 1'b1;
      step(1);
      chk("R7 resume", count_q, 32'd3);

      // R8: both phases flip together
      ab_st = ab_st ^ 2'b11;
      enc_a = ab_st[1]; enc_b = ab_st[0];
      repeat (wc) @(negedge clk);
      chk("R8 count kept", count_q, 32'd3);
      chk("R8 fault set", {31'd0, err_flag}, 32'd1);
      step(1);
      chk("R8 fault sticky", {31'd0, err_flag}, 32'd1);
      chk("R8 counting continues", count_q, 32'd4);

      snap_ld = 1'b1;
      @(negedge clk);
      snap_ld = 1'b0;
      @(negedge clk);
      chk("R12 snapshot", snap_q, 32'd4);
      step(1);
      chk("R12 snapshot held", snap_q, 32'd4);

      cfg_idx_clr = 1'b0;
      idx_pulse(4);
      chk("R9 marker disabled", count_q, 32'd5);
      cfg_idx_clr = 1'b1;
      enc_idx = 1'b1;
      repeat (wc) @(negedge clk);
      exp_cnt = 32'd0;
      chk("R9 direct clear", count_q, 32'd0);
      repeat (2) step(1);
      chk("R9 once per pulse", count_q, 32'd2);
      enc_idx = 1'b0;
      repeat (wc) @(negedge clk);

      step(1);
      idx_pulse(2);
      exp_cnt = 32'd0;
      chk("R3 full rate short pulse", count_q, 32'd0);
      cfg_fdiv2 = 1'b1; wc = 12;
      repeat (3) step(1);
      idx_pulse(2);
      chk("R3 half rate short pulse ignored", count_q, 32'd3);
      idx_pulse(4);
      exp_cnt = 32'd0;
      chk("R3 half rate long pulse", count_q, 32'd0);
      cfg_fdiv2 = 1'b0; wc = 6;

      cfg_idx_sync = 1'b1;
      repeat (4) step(1);
      while (ab_st != 2'b10) step(1);
      hold = count_q;
      enc_idx = 1'b1;
      repeat (wc) @(negedge clk);
      chk("R10 no clear away from 00", count_q, hold);
      step(0);
      exp_cnt = 32'd0;
      chk("R10 qualified clear wins", count_q, 32'd0);
      enc_idx = 1'b0;
      repeat (wc) @(negedge clk);
      cfg_idx_sync = 1'b0;
      cfg_idx_clr = 1'b0;

      write_cmp(exp_cnt + 32'd3);
      p0 = pls;
      repeat (3) step(1);
      chk("R11 count at compare", count_q, exp_cmp);
      chk("R11 single pulse", pls - p0, 1);
      step(1);
      chk("R11 no pulse after", pls - p0, 1);

      write_cmp(exp_cnt + 32'd2 + ($urandom % 5));
      p0 = pls;
      exp_pls = 0;
      for (int i = 0; i < 200; i++) begin
         cnt_en = (($urandom % 10) < 8);
         step(($urandom % 10) < 6);
         if (i % 25 == 24) chk("R4 R5 R7 random walk", count_q, exp_cnt);
      end
      cnt_en = 1'b1;
      chk("R11 random pulse count", pls - p0, exp_pls);
      summary();
   end

endmodule